// File: doc/BRIEF.md
# Synchronous Burst SRAM Model

This block is a cycle-accurate, synthesizable model of a single-port synchronous SRAM. It has a two-bit burst address counter and flow-through read data. Every control input is sampled on the rising clock edge. An access starts on an edge where one of two address strobes is low: the processor strobe or the controller strobe. That edge captures the address and the combined state of the three chip enables. On later edges the advance input steps through a four-beat burst. The burst order is interleaved or linear, chosen by a mode input that is captured when the address loads. Words are split into byte lanes that can be written separately. A global write input writes every lane at once.

Read data is flow-through. The word at the registered address appears on the output during the cycle that follows the edge that registered it, with no pipeline stage in between. The data bus is split into a write-data input, a read-data output and a drive flag, which takes the place of a tri-state pin. The model has no handshake and no back-pressure: it accepts a command on every edge where it is awake.

A snooze input moves the array into sleep through a fixed four-edge entry window. Leaving sleep takes a fixed four-edge wake window. No access is accepted during either window. Memory contents are kept through sleep.

Top module: `syncburst_sram`

## Requirements
- R1: An edge where `cpu_strobe_n` or `ctl_strobe_n` is low loads the address and captures the select state (`sel_a_n` low, `sel_b` high and `sel_c_n` low). The burst beat restarts at zero. On edges with both strobes high, changes on the select inputs have no effect.
- R2: An edge with `cpu_strobe_n` low is always a read, and the memory is not modified even if write strobes are active.
- R3: With `all_wr_n` low, all four lanes are written. Otherwise, with `lane_wr_en_n` low, lane i is written when `lane_n[i]` is low. Lane i holds data bits 9i+8 down to 9i. With `lane_wr_en_n` and `all_wr_n` both high, nothing is written.
- R4: A write on a `ctl_strobe_n` edge goes to the newly loaded address. A write on an edge with both strobes high goes to the current burst address. That address is first advanced when `step_n` is low.
- R5: After an edge that selects an address for reading, `rd_data` equals that word in the same cycle. `rd_drive` is high while `out_en_n` is low and low while `out_en_n` is high.
- R6: In the cycle after a write edge, `rd_drive` stays low whatever `out_en_n` is.
- R7: While the captured select state is inactive, `rd_drive` is low and writes are ignored.
- R8: With `order_sel` high at the load edge, the low two address bits at beat b are the start offset XOR b.
- R9: With `order_sel` low at the load edge, the low two address bits are (start + b) mod 4. The burst wraps after four beats. The upper address bits and the order do not change during the burst.
- R10: An edge with `step_n` low and no strobe advances the beat by one. With `step_n` high, the beat holds.
- R11: An awake edge that samples `snooze` high starts a four-edge entry window. From that edge on, no access is accepted and `rd_drive` is low. Contents are kept through sleep.
- R12: An edge in sleep that samples `snooze` low starts a four-edge wake window. The first access accepted is on the fifth edge.
- R13: After reset the model is awake and deselected, and `rd_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW (6) | Word address, loaded on a strobe edge |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| cpu_strobe_n | input | 1 | Processor address strobe, active low, read-only start |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| lane_wr_en_n | input | 1 | Enables per-lane writes, active low |
| lane_n | input | LANES (4) | Per-lane write strobes, active low |
| out_en_n | input | 1 | Output enable, active low |
| order_sel | input | 1 | 1 = interleaved burst, 0 = linear |
| snooze | input | 1 | Sleep request, active high |
| wr_data | input | 36 | Write data |
| rd_data | output | 36 | Read data, zero when not driven |
| rd_drive | output | 1 | High when read data is driven |

## Verification
Two functions can fall on the same edge: a sleep request and an access. The bench raises `snooze` on the same edge as a processor-strobe read load, then issues a controller-strobe write during the entry window. The model passes if the bus stays undriven through entry, sleep and wake, and if the word read back after wake-up still holds its value from before sleep. A second overlap is a write with output enable low. It is judged by `rd_drive` staying low in the cycle after the write.

// File: rtl/syncburst_pkg.sv
package syncburst_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    PWR_AWAKE  = 2'd0,
    PWR_ENTER  = 2'd1,
    PWR_ASLEEP = 2'd2,
    PWR_WAKE   = 2'd3
  } pwr_state_e;

  // Low address bits for a given beat of a burst.
  function automatic logic [BURST_W-1:0] beat_offset(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] beat,
    input logic               interleave
  );
    if (interleave) return start ^ beat;
    return start + beat;
  endfunction
endpackage

// File: rtl/syncburst_addr_ctr.sv
module syncburst_addr_ctr
  import syncburst_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               load,
  input  logic               en_in,
  input  logic [AW-1:0]      addr_in,
  input  logic               order_in,
  input  logic               step_n,
  output logic               selected,
  output logic               next_sel,
  output logic [BURST_W-1:0] beat,
  output logic [AW-1:0]      cur_addr,
  output logic [AW-1:0]      next_addr
);
  logic               sel_q, sel_d;
  logic [AW-1:0]      base_q, base_d;
  logic [BURST_W-1:0] beat_q, beat_d;
  logic               order_q, order_d;

  always_comb begin
    sel_d   = sel_q;
    base_d  = base_q;
    beat_d  = beat_q;
    order_d = order_q;
    if (!accept) begin
      sel_d = 1'b0;
    end else if (load) begin
      sel_d = en_in;
      if (en_in) begin
        base_d  = addr_in;
        beat_d  = '0;
        order_d = order_in;
      end
    end else if (!step_n && sel_q) begin
      beat_d = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      base_q  <= '0;
      beat_q  <= '0;
      order_q <= 1'b1;
    end else begin
      sel_q   <= sel_d;
      base_q  <= base_d;
      beat_q  <= beat_d;
      order_q <= order_d;
    end
  end

  assign selected  = sel_q;
  assign next_sel  = sel_d;
  assign beat      = beat_q;
  assign cur_addr  = {base_q[AW-1:BURST_W], beat_offset(base_q[BURST_W-1:0], beat_q, order_q)};
  assign next_addr = {base_d[AW-1:BURST_W], beat_offset(base_d[BURST_W-1:0], beat_d, order_d)};
endmodule

// File: rtl/syncburst_snooze.sv
module syncburst_snooze
  import syncburst_pkg::*;
#(
  parameter int SLEEP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic snooze,
  output logic awake,
  output logic accept
);
  localparam int CW = $clog2(SLEEP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SLEEP_CYC - 1);

  pwr_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_AWAKE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PWR_AWAKE: if (snooze) begin
          state_q <= PWR_ENTER;
          cnt_q   <= CW'(1);
        end
        PWR_ENTER: if (cnt_q == LAST) begin
          state_q <= PWR_ASLEEP;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        PWR_ASLEEP: if (!snooze) begin
          state_q <= PWR_WAKE;
          cnt_q   <= CW'(1);
        end
        PWR_WAKE: if (cnt_q == LAST) begin
          state_q <= PWR_AWAKE;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          state_q <= PWR_AWAKE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign awake  = (state_q == PWR_AWAKE);
  assign accept = awake && !snooze;
endmodule

// File: rtl/syncburst_lane_array.sv
module syncburst_lane_array #(
  parameter int DEPTH  = 64,
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we_lane,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we_lane[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/syncburst_sram.sv
module syncburst_sram
  import syncburst_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int LANES     = 4,
  parameter int LANE_W    = 9,
  parameter int SLEEP_CYC = 4,
  localparam int AW       = $clog2(DEPTH),
  localparam int DW       = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             cpu_strobe_n,
  input  logic             ctl_strobe_n,
  input  logic             step_n,
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             out_en_n,
  input  logic             order_sel,
  input  logic             snooze,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic             rd_drive
);
  logic               awake, accept;
  logic               selected, next_sel;
  logic [BURST_W-1:0] beat;
  logic [AW-1:0]      cur_addr, next_addr;
  logic [DW-1:0]      arr_rdata;
  logic [LANES-1:0]   lane_mask, we_lane;
  logic               chip_en, load, wr_req, wr_fire, last_wr_q;

  assign chip_en = !sel_a_n && sel_b && !sel_c_n;
  assign load    = !cpu_strobe_n || !ctl_strobe_n;

  syncburst_snooze #(.SLEEP_CYC(SLEEP_CYC)) u_snooze (
    .clk(clk), .rst_n(rst_n), .snooze(snooze), .awake(awake), .accept(accept)
  );

  syncburst_addr_ctr #(.AW(AW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .accept(accept), .load(load), .en_in(chip_en),
    .addr_in(addr), .order_in(order_sel), .step_n(step_n),
    .selected(selected), .next_sel(next_sel), .beat(beat),
    .cur_addr(cur_addr), .next_addr(next_addr)
  );

  always_comb begin
    if (!all_wr_n)          lane_mask = '1;
    else if (!lane_wr_en_n) lane_mask = ~lane_n;
    else                    lane_mask = '0;
  end

  assign wr_req  = |lane_mask;
  assign wr_fire = accept && cpu_strobe_n && wr_req && next_sel;
  assign we_lane = wr_fire ? lane_mask : '0;

  syncburst_lane_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we_lane(we_lane), .waddr(next_addr), .wdata(wr_data),
    .raddr(cur_addr), .rdata(arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_wr_q <= 1'b0;
    else        last_wr_q <= wr_fire;
  end

  assign rd_drive = awake && selected && !last_wr_q && !out_en_n;
  assign rd_data  = rd_drive ? arr_rdata : '0;
endmodule

// File: rtl/syncburst_sram_chk.sv
module syncburst_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_strobe_n,
  input logic       ctl_strobe_n,
  input logic       step_n,
  input logic       snooze,
  input logic       out_en_n,
  input logic       rd_drive,
  input logic       wr_fire,
  input logic       accept,
  input logic       awake,
  input logic       selected,
  input logic [1:0] beat
);
  AST_CPU_START_READS: assert property (@(posedge clk) disable iff (!rst_n) !cpu_strobe_n |-> !wr_fire); // R2
  AST_WRITE_MUTES_BUS: assert property (@(posedge clk) disable iff (!rst_n) wr_fire |=> !rd_drive); // R6
  AST_DESELECT_MUTES: assert property (@(posedge clk) disable iff (!rst_n) !selected |-> !rd_drive); // R7
  AST_OE_MUTES: assert property (@(posedge clk) disable iff (!rst_n) out_en_n |-> !rd_drive); // R5
  AST_SLEEP_MUTES: assert property (@(posedge clk) disable iff (!rst_n) !awake |-> !rd_drive); // R11
  AST_SNOOZE_LEAVES_AWAKE: assert property (@(posedge clk) disable iff (!rst_n) (awake && snooze) |=> !awake); // R11
  AST_LOAD_ZEROES_BEAT: assert property (@(posedge clk) disable iff (!rst_n) (accept && !(cpu_strobe_n && ctl_strobe_n)) |=> (!selected || beat == 2'd0)); // R1
  AST_STEP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n) (accept && cpu_strobe_n && ctl_strobe_n && !step_n && selected) |=> beat == $past(beat) + 2'd1); // R10
  AST_BEAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (accept && cpu_strobe_n && ctl_strobe_n && step_n) |=> ($stable(beat) && $stable(selected))); // R10
endmodule

bind syncburst_sram syncburst_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
  .step_n(step_n), .snooze(snooze), .out_en_n(out_en_n), .rd_drive(rd_drive),
  .wr_fire(wr_fire), .accept(accept), .awake(awake), .selected(selected), .beat(beat)
);

// File: tb/syncburst_sram_bench.sv
`timescale 1ns/1ps
module syncburst_sram_bench;
  localparam int DEPTH = 64;
  localparam int AW    = 6;
  localparam int DW    = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          sel_a_n, sel_b, sel_c_n;
  logic          cpu_strobe_n, ctl_strobe_n, step_n;
  logic          all_wr_n, lane_wr_en_n;
  logic [3:0]    lane_n;
  logic          out_en_n, order_sel, snooze;
  logic [DW-1:0] wr_data, rd_data;
  logic          rd_drive;

  logic [DW-1:0] ref_mem [DEPTH];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  syncburst_sram u_syncburst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
    .step_n(step_n), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_n(lane_n), .out_en_n(out_en_n), .order_sel(order_sel), .snooze(snooze),
    .wr_data(wr_data), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b1; step_n = 1'b1;
    all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_n = 4'hF;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    out_en_n = 1'b0; snooze = 1'b0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr_single(input logic [AW-1:0] a, input logic [DW-1:0] d);
    idle_in();
    addr = a; ctl_strobe_n = 1'b0; all_wr_n = 1'b0; wr_data = d;
    tick();
    ref_mem[a] = d;
    chk("R6 bus idle after write", {35'd0, rd_drive}, 36'd0);
    idle_in();
  endtask

  task automatic rd_load(input logic [AW-1:0] a, input logic ord, input string req);
    idle_in();
    addr = a; cpu_strobe_n = 1'b0; order_sel = ord;
    tick();
    chk(req, {35'd0, rd_drive}, 36'd1);
    chk(req, rd_data, ref_mem[a]);
    idle_in();
  endtask

  task automatic t_reset();
    chk("R13 reset drive low", {35'd0, rd_drive}, 36'd0);
  endtask

  task automatic t_single();
    wr_single(6'd5, 36'h123456789);
    rd_load(6'd5, 1'b1, "R5 flow-through read");
    out_en_n = 1'b1;
    #1;
    chk("R5 out_en high mutes", {35'd0, rd_drive}, 36'd0);
    out_en_n = 1'b0;
    // processor strobe with write strobes active stays a read
    addr = 6'd5; cpu_strobe_n = 1'b0; all_wr_n = 1'b0; wr_data = 36'h0DEADBEEF;
    tick();
    chk("R2 cpu start is read (drive)", {35'd0, rd_drive}, 36'd1);
    chk("R2 cpu start is read (data)", rd_data, ref_mem[5]);
    idle_in();
  endtask

  task automatic t_lanes();
    logic [DW-1:0] d;
    wr_single(6'd12, 36'h123456789);
    // global write overrides lane strobes
    addr = 6'd12; ctl_strobe_n = 1'b0; all_wr_n = 1'b0; lane_wr_en_n = 1'b0;
    lane_n = 4'b1110; wr_data = 36'h987654321;
    tick();
    ref_mem[12] = 36'h987654321;
    idle_in();
    rd_load(6'd12, 1'b1, "R3 global write all lanes");
    d = 36'hABCDEF012;
    addr = 6'd12; ctl_strobe_n = 1'b0; lane_wr_en_n = 1'b0; lane_n = 4'b1010; wr_data = d;
    tick();
    for (int i = 0; i < 4; i++) if (!lane_n[i]) ref_mem[12][9*i +: 9] = d[9*i +: 9];
    chk("R6 bus idle after lane write", {35'd0, rd_drive}, 36'd0);
    idle_in();
    rd_load(6'd12, 1'b1, "R3 partial lane write");
    // lane strobes without lane enable: plain read
    addr = 6'd12; ctl_strobe_n = 1'b0; lane_n = 4'h0; wr_data = 36'h000000000;
    tick();
    chk("R3 lanes need enable (data)", rd_data, ref_mem[12]);
    chk("R3 lanes need enable (drive)", {35'd0, rd_drive}, 36'd1);
    idle_in();
  endtask

  task automatic burst_rd(input logic [AW-1:0] base, input logic [1:0] st, input logic il, input string req);
    logic [1:0] off;
    rd_load(base | AW'(st), il, req);
    for (int b = 1; b <= 5; b++) begin
      step_n = 1'b0;
      order_sel = ~il;  // order must stay as captured at load
      tick();
      off = il ? (st ^ 2'(b)) : (st + 2'(b));
      chk(req, rd_data, ref_mem[base | AW'(off)]);
    end
    step_n = 1'b1;
    tick();
    chk("R10 hold without step", rd_data, ref_mem[base | AW'(off)]);
    idle_in();
  endtask

  task automatic t_bursts();
    for (int i = 0; i < 8; i++) wr_single(AW'(16 + i), 36'h0A5000000 + DW'(i * 36'h111));
    burst_rd(6'd16, 2'd2, 1'b1, "R8 interleaved burst");
    burst_rd(6'd20, 2'd3, 1'b0, "R9 linear burst");
    burst_rd(6'd16, 2'd1, 1'b0, "R9 linear burst from 1");
  endtask

  task automatic t_burst_write();
    addr = 6'd24; ctl_strobe_n = 1'b0; all_wr_n = 1'b0; order_sel = 1'b1; wr_data = 36'h111111111;
    tick(); ref_mem[24] = 36'h111111111;
    idle_in();
    all_wr_n = 1'b0; step_n = 1'b0; wr_data = 36'h222222222;
    tick(); ref_mem[25] = 36'h222222222;
    wr_data = 36'h333333333;
    tick(); ref_mem[26] = 36'h333333333;
    step_n = 1'b1; wr_data = 36'h444444444;
    tick(); ref_mem[26] = 36'h444444444;
    chk("R6 bus idle during burst write", {35'd0, rd_drive}, 36'd0);
    idle_in();
    rd_load(6'd24, 1'b1, "R4 burst write beat 0");
    rd_load(6'd25, 1'b1, "R4 burst write beat 1");
    rd_load(6'd26, 1'b1, "R4 burst write held beat");
  endtask

  task automatic t_deselect();
    wr_single(6'd9, 36'h0C0FFEE01);
    rd_load(6'd9, 1'b1, "R1 load before deselect");
    sel_b = 1'b0;
    tick();
    chk("R1 select ignored without strobe", {35'd0, rd_drive}, 36'd1);
    addr = 6'd9; ctl_strobe_n = 1'b0;
    tick();
    chk("R7 deselected drive", {35'd0, rd_drive}, 36'd0);
    ctl_strobe_n = 1'b1; all_wr_n = 1'b0; wr_data = 36'hBADBADBAD;
    tick();
    chk("R7 deselected drive during write", {35'd0, rd_drive}, 36'd0);
    idle_in();
    sel_a_n = 1'b1; addr = 6'd9; ctl_strobe_n = 1'b0; all_wr_n = 1'b0; wr_data = 36'hBADBADBAD;
    tick();
    idle_in();
    rd_load(6'd9, 1'b1, "R7 deselected writes ignored");
  endtask

  task automatic t_sleep();
    rd_load(6'd5, 1'b1, "R11 read before sleep");
    snooze = 1'b1; addr = 6'd9; cpu_strobe_n = 1'b0;
    tick();
    chk("R11 entry edge mutes bus", {35'd0, rd_drive}, 36'd0);
    cpu_strobe_n = 1'b1; addr = 6'd5; ctl_strobe_n = 1'b0; all_wr_n = 1'b0; wr_data = 36'h0FFFFFFFF;
    tick();
    chk("R11 no access in entry", {35'd0, rd_drive}, 36'd0);
    idle_in(); snooze = 1'b1;
    tick(); tick(); tick();
    chk("R11 asleep drive", {35'd0, rd_drive}, 36'd0);
    snooze = 1'b0;
    tick(); tick(); tick();
    addr = 6'd5; cpu_strobe_n = 1'b0;
    tick();
    chk("R12 fourth wake edge not accepted", {35'd0, rd_drive}, 36'd0);
    tick();
    chk("R12 fifth edge accepted", {35'd0, rd_drive}, 36'd1);
    chk("R11 contents kept through sleep", rd_data, ref_mem[5]);
    idle_in();
  endtask

  initial begin
    idle_in();
    addr = '0; order_sel = 1'b1; wr_data = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_single();
    t_lanes();
    t_bursts();
    t_burst_write();
    t_deselect();
    t_sleep();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog R1-wide run: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule